// File: doc/BRIEF.md
# Fetch-Packet to Execute-Packet Dispatcher

This block is the front end of a wide-issue instruction pipeline. It fetches 256-bit fetch packets, each holding eight 32-bit instructions, from a synchronous instruction memory. It carries each packet through six single-cycle front-end phases: address generate, address send, wait, receive, dispatch and decode. In the decode phase it cuts the packet into execute packets, which are groups of consecutive instructions that issue together. Bit 0 of every instruction is a chain flag. When it is 1, the following instruction joins the same group. The last lane always closes its group.

Each cycle, at most one execute packet leaves the block. It is presented as a lane mask over the eight instruction words, with the packet address alongside, under a valid/ready handshake. While a fetch packet still has groups waiting, the packet stays in the decode phase and every upstream phase holds. The fetch side therefore sends fewer requests. A flush input empties every phase and restarts fetching at a supplied address. A free-running counter records each cycle in which nothing issues.

The memory interface works as follows. The block asserts a request with an address. The memory registers the addressed line on that clock edge and holds it until the next request. The block captures that line when the request moves from the wait phase into the receive phase.

Top module: `exec_packet_dispatcher`

## Requirements
- R1: While reset is asserted, `ep_valid_o` and `imem_req_o` are 0 and `idle_cycles_o` is 0. The first fetch request appears in cycle 1 after reset release (cycle 0 being the first cycle with reset deasserted), at address `RESET_ADDR`.
- R2: An execute packet starts at the first lane not yet issued. It extends through each lane whose instruction bit 0 is 1 and ends at the first lane whose bit 0 is 0. `ep_lanes_o` is a contiguous nonzero mask. Lane i's word sits at `ep_words_o[32i+31:32i]`. `ep_pc_o` is the fetch packet's byte address.
- R3: Lane 7 always ends an execute packet, whatever its bit 0 holds, so no execute packet spans two fetch packets.
- R4: Execute packets are handed over one per handshake, in lane order within a packet. Packets are handed over in fetch order. Fetch addresses step by 32 from the start address.
- R5: After reset, the first execute packet is valid in cycle 5. When every packet is a single execute packet and `ep_ready_i` stays high, one issues every cycle with no gap.
- R6: A fetch packet that splits into several execute packets stays in decode for one handshake per execute packet and holds all earlier phases meanwhile. Issue stays continuous, and fetch requests fall to about one per fetch packet.
- R7: While `ep_valid_o` is high and `ep_ready_i` is low, the next cycle keeps `ep_valid_o` high with the same lane mask.
- R8: A flush drops the packet held in decode and all earlier phases. `ep_valid_o` is 0 in the cycle after the flush. The next fetch request carries `flush_addr_i`. The dropped execute packets never issue.
- R9: `idle_cycles_o` counts, modulo 2^CW, every cycle since reset release that has no handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Drop all in-flight packets and restart fetch |
| flush_addr_i | input | AW | Restart address used with flush_i |
| imem_req_o | output | 1 | Fetch request to instruction memory |
| imem_addr_o | output | AW | Fetch packet byte address |
| imem_rdata_i | input | 256 | Line returned by the memory, held until the next request |
| ep_valid_o | output | 1 | An execute packet is offered |
| ep_ready_i | input | 1 | Consumer accepts the offered execute packet |
| ep_lanes_o | output | 8 | Lanes that belong to the offered execute packet |
| ep_words_o | output | 256 | All eight instruction words of the current fetch packet |
| ep_pc_o | output | AW | Byte address of the current fetch packet |
| idle_cycles_o | output | CW | Count of cycles without an issue |

## Verification
The hardest state to reach from the ports is a fetch packet that is only partly issued when a flush lands. In that state the remaining execute packets must vanish, not leak out after the restart. The bench gets there by queuing only the first three groups of a packet whose lanes all end their own group. It drops ready the moment those three have left, which parks the block with a half-consumed packet in decode. It then flushes to a new address and expects that address's first packet next. Separate phases cover two other cases: a lane-7 chain bit set with all other bits clear, and a packet whose only closing lane is lane 7. Random backpressure over hashed chain patterns exercises the hold behaviour.

// File: rtl/fpd_pkg.sv
package fpd_pkg;
  localparam int unsigned LANES  = 8;
  localparam int unsigned IW     = 32;
  localparam int unsigned LINE_W = LANES * IW;
  localparam int unsigned LW     = $clog2(LANES);

  typedef logic [LW-1:0]    lane_t;
  typedef logic [LANES-1:0] lmask_t;

  // Gather bit 0 of each instruction word of a fetch line.
  function automatic lmask_t chain_bits(logic [LINE_W-1:0] line);
    lmask_t r;
    for (int i = 0; i < LANES; i++) r[i] = line[i*IW];
    return r;
  endfunction

  // Lane that closes the execute packet starting at 'first'.
  function automatic lane_t packet_end(lmask_t chain, lane_t first);
    lane_t e;
    logic  found;
    e     = lane_t'(LANES-1);
    found = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (!found && i >= int'(first) && (!chain[i] || i == LANES-1)) begin
        e     = lane_t'(i);
        found = 1'b1;
      end
    end
    return e;
  endfunction

  // Contiguous lane mask from lo to hi inclusive.
  function automatic lmask_t span(lane_t lo, lane_t hi);
    lmask_t m;
    for (int i = 0; i < LANES; i++) m[i] = (i >= int'(lo)) && (i <= int'(hi));
    return m;
  endfunction
endpackage

// File: rtl/fpd_pc_gen.sv
module fpd_pc_gen #(
  parameter int unsigned AW         = 32,
  parameter int unsigned STEP       = 32,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [AW-1:0] flush_addr,
  input  logic          adv,
  output logic [AW-1:0] pc
);
  always_ff @(posedge clk) begin
    if (!rst_n)     pc <= RESET_ADDR;
    else if (flush) pc <= flush_addr;
    else if (adv)   pc <= pc + AW'(STEP);
  end
endmodule

// File: rtl/fpd_stage.sv
module fpd_stage #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready
);
  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (flush) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  // R7: a stalled phase keeps its content
  p_stage_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !flush |=> out_valid && $stable(out_data));
endmodule

// File: rtl/fpd_splitter.sv
module fpd_splitter
  import fpd_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_valid,
  input  logic [AW-1:0]     in_addr,
  input  logic [LINE_W-1:0] in_line,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output lmask_t            out_lanes,
  output logic [LINE_W-1:0] out_line,
  output logic [AW-1:0]     out_addr,
  output logic              fire
);
  logic              held;
  logic [LINE_W-1:0] line_q;
  logic [AW-1:0]     addr_q;
  lane_t             first_q;
  lane_t             last;
  logic              closes_packet;

  assign last          = packet_end(chain_bits(line_q), first_q);
  assign closes_packet = (last == lane_t'(LANES-1));
  assign out_valid     = held & ~flush;
  assign out_lanes     = span(first_q, last);
  assign out_line      = line_q;
  assign out_addr      = addr_q;
  assign fire          = out_valid & out_ready;
  assign in_ready      = ~held | (fire & closes_packet);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held    <= 1'b0;
      first_q <= '0;
      line_q  <= '0;
      addr_q  <= '0;
    end else if (flush) begin
      held    <= 1'b0;
      first_q <= '0;
    end else if (in_ready) begin
      held    <= in_valid;
      first_q <= '0;
      if (in_valid) begin
        line_q <= in_line;
        addr_q <= in_addr;
      end
    end else if (fire) begin
      first_q <= lane_t'(last + 1'b1);
    end
  end

  // R2: offered lanes are a nonempty contiguous run
  p_lanes_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_lanes != '0);
  p_lanes_contig_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_lanes + (out_lanes & (~out_lanes + 1'b1))) & out_lanes) == '0);
  // R6: a packet with lanes left stays in decode
  p_stay_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !out_lanes[LANES-1] |=> held);
endmodule

// File: rtl/fpd_idle_ctr.sv
module fpd_idle_ctr #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)     count <= '0;
    else if (!fire) count <= count + 1'b1;
  end

  // R9: one step per silent cycle, none otherwise
  p_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> count == $past(count) + 1'b1);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> $stable(count));
endmodule

// File: rtl/exec_packet_dispatcher.sv
module exec_packet_dispatcher
  import fpd_pkg::*;
#(
  parameter int unsigned   AW         = 32,
  parameter int unsigned   CW         = 16,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic [AW-1:0]     flush_addr_i,
  output logic              imem_req_o,
  output logic [AW-1:0]     imem_addr_o,
  input  logic [LINE_W-1:0] imem_rdata_i,
  output logic              ep_valid_o,
  input  logic              ep_ready_i,
  output logic [LANES-1:0]  ep_lanes_o,
  output logic [LINE_W-1:0] ep_words_o,
  output logic [AW-1:0]     ep_pc_o,
  output logic [CW-1:0]     idle_cycles_o
);
  localparam int unsigned STEP  = LINE_W / 8;
  localparam int unsigned PKT_W = AW + LINE_W;

  // Named internal events
  logic              fetch_hold;
  logic              issue_fire;

  logic [AW-1:0]     pc;
  logic              ps_in_ready, ps_valid;
  logic [AW-1:0]     ps_addr;
  logic              pw_in_ready, pw_valid;
  logic [AW-1:0]     pw_addr;
  logic              pr_in_ready, pr_valid;
  logic [PKT_W-1:0]  pr_data;
  logic              dp_in_ready, dp_valid;
  logic [PKT_W-1:0]  dp_data;
  logic              dc_in_ready;

  assign fetch_hold = ~ps_in_ready;

  // Address generate
  fpd_pc_gen #(.AW(AW), .STEP(STEP), .RESET_ADDR(RESET_ADDR)) u_pc (
    .clk(clk), .rst_n(rst_n), .flush(flush_i), .flush_addr(flush_addr_i),
    .adv(~fetch_hold), .pc(pc));

  // Address send
  fpd_stage #(.W(AW)) u_ps (
    .clk(clk), .rst_n(rst_n), .flush(flush_i),
    .in_valid(1'b1), .in_data(pc), .in_ready(ps_in_ready),
    .out_valid(ps_valid), .out_data(ps_addr), .out_ready(pw_in_ready));

  assign imem_req_o  = ps_valid & pw_in_ready & ~flush_i;
  assign imem_addr_o = ps_addr;

  // Wait for the memory
  fpd_stage #(.W(AW)) u_pw (
    .clk(clk), .rst_n(rst_n), .flush(flush_i),
    .in_valid(ps_valid), .in_data(ps_addr), .in_ready(pw_in_ready),
    .out_valid(pw_valid), .out_data(pw_addr), .out_ready(pr_in_ready));

  // Receive the line
  fpd_stage #(.W(PKT_W)) u_pr (
    .clk(clk), .rst_n(rst_n), .flush(flush_i),
    .in_valid(pw_valid), .in_data({pw_addr, imem_rdata_i}), .in_ready(pr_in_ready),
    .out_valid(pr_valid), .out_data(pr_data), .out_ready(dp_in_ready));

  // Dispatch
  fpd_stage #(.W(PKT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .flush(flush_i),
    .in_valid(pr_valid), .in_data(pr_data), .in_ready(dp_in_ready),
    .out_valid(dp_valid), .out_data(dp_data), .out_ready(dc_in_ready));

  // Decode and split into execute packets
  fpd_splitter #(.AW(AW)) u_dc (
    .clk(clk), .rst_n(rst_n), .flush(flush_i),
    .in_valid(dp_valid), .in_addr(dp_data[PKT_W-1:LINE_W]), .in_line(dp_data[LINE_W-1:0]),
    .in_ready(dc_in_ready),
    .out_valid(ep_valid_o), .out_ready(ep_ready_i), .out_lanes(ep_lanes_o),
    .out_line(ep_words_o), .out_addr(ep_pc_o), .fire(issue_fire));

  fpd_idle_ctr #(.CW(CW)) u_idle (
    .clk(clk), .rst_n(rst_n), .fire(issue_fire), .count(idle_cycles_o));

  // R8: nothing offered right after a flush
  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !ep_valid_o);
  // R4: back-to-back requests walk forward one line
  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    imem_req_o && $past(imem_req_o) |-> imem_addr_o == $past(imem_addr_o) + AW'(STEP));
endmodule

// File: tb/test_exec_packet_dispatcher.sv
module test_exec_packet_dispatcher;
  localparam int AW = 32;
  localparam int CW = 16;
  localparam int NL = 8;
  localparam int WW = 32;
  localparam int LW = NL * WW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flush = 1'b0;
  logic [AW-1:0] faddr = '0;
  logic          req;
  logic [AW-1:0] raddr;
  logic [LW-1:0] rdata = '0;
  logic          ep_valid;
  logic          ready = 1'b0;
  logic [NL-1:0] lanes;
  logic [LW-1:0] words;
  logic [AW-1:0] pc;
  logic [CW-1:0] idle;

  int tests = 0, fails = 0;
  int mode = 0;
  logic [AW+NL-1:0] q[$];

  always #2 clk = ~clk;  // 250 MHz

  exec_packet_dispatcher i_exec_packet_dispatcher (
    .clk(clk), .rst_n(rst_n), .flush_i(flush), .flush_addr_i(faddr),
    .imem_req_o(req), .imem_addr_o(raddr), .imem_rdata_i(rdata),
    .ep_valid_o(ep_valid), .ep_ready_i(ready), .ep_lanes_o(lanes),
    .ep_words_o(words), .ep_pc_o(pc), .idle_cycles_o(idle));

  function automatic logic [NL-1:0] pbits(logic [AW-1:0] a, int m);
    case (m)
      0: return 8'hFF;
      1: return 8'h00;
      2: return 8'(a[12:5] * 8'd37) ^ 8'h5A;
      3: return 8'h7F;
      default: return 8'h80;
    endcase
  endfunction

  function automatic logic [WW-1:0] iword(logic [AW-1:0] a, int l, int m);
    logic [NL-1:0] pb;
    pb = pbits(a, m);
    return {a[20:5], 8'(l), 7'h0, pb[l]};
  endfunction

  function automatic logic [LW-1:0] mem_line(logic [AW-1:0] a, int m);
    logic [LW-1:0] r;
    for (int l = 0; l < NL; l++) r[l*WW +: WW] = iword(a, l, m);
    return r;
  endfunction

  // Synchronous memory: line registered on request, held otherwise
  always @(posedge clk) if (req) rdata <= mem_line(raddr, mode);

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // Driver side: expected execute packets from the requirements
  task automatic expect_packets(input logic [AW-1:0] a, input int n, input int m);
    for (int p = 0; p < n; p++) begin
      logic [AW-1:0] pa;
      logic [NL-1:0] pb;
      int s;
      pa = a + AW'(32 * p);
      pb = pbits(pa, m);
      s = 0;
      while (s < NL) begin
        int e;
        logic [NL-1:0] mk;
        e = s;
        while (e < NL-1 && pb[e]) e++;
        mk = '0;
        for (int l = s; l <= e; l++) mk[l] = 1'b1;
        q.push_back({pa, mk});
        s = e + 1;
      end
    end
  endtask

  // Monitor
  int  cyc = 0, idle_exp = 0, idle_err = 0, reset_bad = 0;
  int  first_valid = -1, first_req = -1;
  logic [AW-1:0] first_req_addr = '0;
  bit  prev_stall = 0;
  logic [NL-1:0] prev_mask = '0;
  bit  win = 0;
  int  gap = 0, reqs = 0, stalls = 0;

  always begin
    @(negedge clk); #1;
    if (!rst_n) begin
      if (ep_valid || req || idle != '0) reset_bad++;
    end else begin
      bit fire;
      fire = ep_valid && ready;
      if (idle != CW'(idle_exp)) idle_err++;
      if (ep_valid && first_valid < 0) first_valid = cyc;
      if (req && first_req < 0) begin first_req = cyc; first_req_addr = raddr; end
      if (prev_stall && !flush) begin
        stalls++;
        check(ep_valid && lanes == prev_mask, "R7", "held offer under backpressure",
              {ep_valid, lanes}, {1'b1, prev_mask});
      end
      prev_stall = ep_valid && !ready;
      prev_mask  = lanes;
      if (win && q.size() > 0) begin
        if (!fire) gap++;
        if (req) reqs++;
      end
      if (fire) begin
        win = 1;
        if (q.size() == 0) begin
          check(0, "R4", "unexpected execute packet", {pc, lanes}, 0);
        end else begin
          logic [AW+NL-1:0] e;
          logic [AW-1:0] ea;
          logic [NL-1:0] em;
          bit ok;
          e  = q.pop_front();
          ea = e[AW+NL-1:NL];
          em = e[NL-1:0];
          check(lanes == em && pc == ea, "R2", "lane mask and packet address",
                {pc, lanes}, {ea, em});
          ok = 1;
          for (int l = 0; l < NL; l++)
            if (em[l] && words[l*WW +: WW] != iword(ea, l, mode)) ok = 0;
          check(ok, "R2", "instruction words of issued lanes", ok, 1);
        end
      end
      if (!fire) idle_exp++;
      cyc++;
    end
  end

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    ready = 1'b0;
  endtask

  task automatic do_flush(input logic [AW-1:0] a, input int m);
    @(negedge clk);
    mode = m; faddr = a; flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    #1;
    check(!ep_valid, "R8", "offer after flush", ep_valid, 0);
    while (!req) begin @(negedge clk); #1; end
    check(raddr == a, "R8", "first request after flush", raddr, a);
    win = 0; gap = 0; reqs = 0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL R4 watchdog: run still going, expected completion");
    summary();
  end

  initial begin
    // Phase 1: reset, fill, single-EP stream (R1, R5, R4)
    expect_packets(32'h0, 6, 0);
    ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    drain();
    check(reset_bad == 0, "R1", "outputs quiet during reset", reset_bad, 0);
    check(first_req == 1, "R1", "cycle of first request", first_req, 1);
    check(first_req_addr == 32'h0, "R1", "first request address", first_req_addr, 0);
    check(first_valid == 5, "R5", "cycle of first offer", first_valid, 5);
    check(gap == 0, "R5", "gaps in single-EP stream", gap, 0);

    // Phase 2: eight EPs per packet, fetch held (R6)
    do_flush(32'h1000, 1);
    expect_packets(32'h1000, 4, 1);
    ready = 1'b1;
    drain();
    check(gap == 0, "R6", "gaps while splitting", gap, 0);
    check(reqs <= 5, "R6", "fetch requests while splitting", reqs, 5);

    // Phase 3: hashed chains under random backpressure (R2, R7)
    do_flush(32'h2000, 2);
    expect_packets(32'h2000, 20, 2);
    while (q.size() != 0) begin
      @(negedge clk);
      ready = 1'($urandom_range(0, 1));
    end
    ready = 1'b0;
    check(stalls > 0, "R7", "backpressure cycles seen", stalls, 1);

    // Phase 4: lane 7 chain bit set alone, then only lane 7 closes (R3)
    do_flush(32'h3000, 4);
    expect_packets(32'h3000, 3, 4);
    ready = 1'b1;
    drain();
    do_flush(32'h3800, 3);
    expect_packets(32'h3800, 3, 3);
    ready = 1'b1;
    drain();

    // Phase 5: flush with a half-issued packet in decode (R8)
    do_flush(32'h5000, 1);
    q.push_back({32'h5000, 8'h01});
    q.push_back({32'h5000, 8'h02});
    q.push_back({32'h5000, 8'h04});
    ready = 1'b1;
    drain();
    repeat (3) @(negedge clk);
    do_flush(32'h6000, 0);
    expect_packets(32'h6000, 3, 0);
    ready = 1'b1;
    drain();
    repeat (10) @(negedge clk);

    check(q.size() == 0, "R4", "expected packets left", q.size(), 0);
    check(idle_err == 0, "R9", "idle counter mismatching cycles", idle_err, 0);
    check(idle_exp > 0, "R9", "silent cycles counted", idle_exp, 1);
    summary();
  end
endmodule